// File: doc/BRIEF.md
# Dual-Master Clock Configuration Arbiter

This block holds the clock configuration state that two processors share: a PLL multiplier value, a system divider selection and a disable bit for the clock of the secondary processor's domain. Each processor reaches the state through its own simple register port. Each port has a write strobe, a 2-bit address, write data and combinational read data. Write permission for the PLL and divider fields belongs to one master at a time. The main master holds it out of reset. The secondary master takes it over by claiming an ownership semaphore with a key, and hands it back the same way.

Only the main master may set the clock-off bit. The block turns that bit into an enable for the secondary domain's clock. The enable is retimed on the falling edge of the clock, so the gated clock never shows a shortened high phase. The PLL itself and the generation of the clocks lie outside this block.

Top module: `clkarb_top`

## Requirements
- R1: After reset (rst_n low, asynchronous), the PLL field reads 1, the divider field reads 0, the clock-off bit reads 0, the semaphore reads 0 (main master owns) and sec_clk_en is 1.
- R2: Address map: 0 is the PLL field (bits [6:0]), 1 is the divider field (bits [2:0]), 2 is the clock-off bit (bit 0) and 3 is the semaphore. While the main master owns the semaphore, its writes to addresses 0 and 1 update the fields, and both ports read back the new value.
- R3: While the main master owns the semaphore, writes from the secondary port to addresses 0 and 1 leave the fields unchanged.
- R4: A secondary-port write to address 3 whose bits [15:8] equal 8'hA5 sets the owner to the value of bit 0 (1 claims, 0 releases). A write with any other key, and any main-port write to address 3, leaves the owner unchanged.
- R5: While the secondary master owns the semaphore, its writes to addresses 0 and 1 update the fields, and main-port writes to them are ignored.
- R6: When both ports write the same field in the same cycle, the value from the current owner is stored.
- R7: Reading address 3 on either port returns the owner in bit 0 (1 = secondary) and zeros in all other bits.
- R8: Address 2 is written only from the main port. Secondary-port writes to it leave the clock-off bit unchanged.
- R9: sec_clk_en is the inverse of the clock-off bit. It takes a new value at the falling clock edge that follows the rising edge that captured the write, and keeps its old value during the high phase in between.
- R10: sec_clk equals clk AND sec_clk_en. sec_clk_en changes only while clk is low, so every high phase of sec_clk is a full one.
- R11: Bits of the read data above the width of the addressed field read as 0. Write data above the field width is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_we | input | 1 | Main port write strobe |
| m_addr | input | 2 | Main port register address |
| m_wdata | input | 16 | Main port write data |
| m_rdata | output | 16 | Main port read data (combinational) |
| s_we | input | 1 | Secondary port write strobe |
| s_addr | input | 2 | Secondary port register address |
| s_wdata | input | 16 | Secondary port write data |
| s_rdata | output | 16 | Secondary port read data (combinational) |
| sec_clk_en | output | 1 | Enable for the secondary domain clock, retimed on the falling edge |
| sec_clk | output | 1 | Gated clock for the secondary domain |

## Verification
The assertions check the following on every cycle:
- A write from the master that does not own the semaphore never moves the PLL field.
- A keyed semaphore write sets the owner to the claim bit, and a write with a wrong key leaves the owner alone.
- The secondary port cannot move the clock-off bit.
- The enable tracks the inverse of the clock-off bit and changes only while the clock is low.

Only the bench scenarios can show the following:
- The values read back on both ports after each access pattern.
- Which value is stored when both masters write the same field in one cycle, under each owner.
- The half-cycle delay of the enable and the gated clock level in the high phase.
- The return to defaults on a reset taken in the middle of operation.

// File: rtl/clkarb_pkg.sv
package clkarb_pkg;

    typedef enum logic [1:0] {
        REG_PLL  = 2'd0,
        REG_DIV  = 2'd1,
        REG_GATE = 2'd2,
        REG_SEM  = 2'd3
    } reg_sel_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_MAIN = 0;
    localparam int PORT_SEC  = 1;

endpackage

// File: rtl/clkarb_core.sv
module clkarb_core
    import clkarb_pkg::*;
#(
    parameter int DW      = 16,
    parameter int PLL_W   = 7,
    parameter int DIV_W   = 3,
    parameter int KEY_W   = 8,
    parameter int KEY_LSB = 8,
    parameter logic [KEY_W-1:0] KEY     = 8'hA5,
    parameter logic [PLL_W-1:0] PLL_RST = 7'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_we,
    input  logic [1:0]       m_addr,
    input  logic [DW-1:0]    m_wdata,
    input  logic             s_we,
    input  logic [1:0]       s_addr,
    input  logic [DW-1:0]    s_wdata,
    output logic [PLL_W-1:0] pll_q,
    output logic [DIV_W-1:0] div_q,
    output logic             off_q,
    output logic             owner_q
);

    typedef struct packed {
        logic [PLL_W-1:0] pll;
        logic [DIV_W-1:0] div;
        logic             off;
        logic             owner;
    } cfg_t;

    localparam cfg_t CFG_RST = '{pll: PLL_RST, div: '0, off: 1'b0, owner: 1'b0};

    cfg_t st_d, st_q;

    logic m_pll, m_div, m_gate;
    logic s_pll, s_div, s_sem;
    logic key_ok;
    logic unused_wdata;

    assign unused_wdata = ^{m_wdata, s_wdata};

    always_comb begin
        m_pll  = m_we && (m_addr == REG_PLL);
        m_div  = m_we && (m_addr == REG_DIV);
        m_gate = m_we && (m_addr == REG_GATE);
        s_pll  = s_we && (s_addr == REG_PLL);
        s_div  = s_we && (s_addr == REG_DIV);
        s_sem  = s_we && (s_addr == REG_SEM);
        key_ok = (s_wdata[KEY_LSB +: KEY_W] == KEY);

        st_d = st_q;

        // Write rights depend on the owner before this cycle's update.
        if (st_q.owner) begin
            if (s_pll) st_d.pll = s_wdata[PLL_W-1:0];
            if (s_div) st_d.div = s_wdata[DIV_W-1:0];
        end else begin
            if (m_pll) st_d.pll = m_wdata[PLL_W-1:0];
            if (m_div) st_d.div = m_wdata[DIV_W-1:0];
        end

        if (m_gate) st_d.off = m_wdata[0];

        if (s_sem && key_ok) st_d.owner = s_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_RST;
        else        st_q <= st_d;
    end

    assign pll_q   = st_q.pll;
    assign div_q   = st_q.div;
    assign off_q   = st_q.off;
    assign owner_q = st_q.owner;

endmodule

// File: rtl/clkarb_rdmux.sv
module clkarb_rdmux
    import clkarb_pkg::*;
#(
    parameter int DW    = 16,
    parameter int PLL_W = 7,
    parameter int DIV_W = 3
) (
    input  logic [1:0]       addr,
    input  logic [PLL_W-1:0] pll,
    input  logic [DIV_W-1:0] div,
    input  logic             off,
    input  logic             owner,
    output logic [DW-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            REG_PLL:  rdata[PLL_W-1:0] = pll;
            REG_DIV:  rdata[DIV_W-1:0] = div;
            REG_GATE: rdata[0]         = off;
            default:  rdata[0]         = owner;
        endcase
    end

endmodule

// File: rtl/clkarb_gate.sv
module clkarb_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    output logic en,
    output logic gclk
);

    logic en_d, en_q;

    always_comb en_d = ~off;

    // Retimed on the falling edge so the enable moves only in the low phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_d;
    end

    assign en   = en_q;
    assign gclk = clk & en_q;

endmodule

// File: rtl/clkarb_top.sv
module clkarb_top
    import clkarb_pkg::*;
#(
    parameter int DW      = 16,
    parameter int PLL_W   = 7,
    parameter int DIV_W   = 3,
    parameter int KEY_W   = 8,
    parameter int KEY_LSB = 8,
    parameter logic [KEY_W-1:0] KEY     = 8'hA5,
    parameter logic [PLL_W-1:0] PLL_RST = 7'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_we,
    input  logic [1:0]    m_addr,
    input  logic [DW-1:0] m_wdata,
    output logic [DW-1:0] m_rdata,
    input  logic          s_we,
    input  logic [1:0]    s_addr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          sec_clk_en,
    output logic          sec_clk
);

    logic [PLL_W-1:0] pll_q;
    logic [DIV_W-1:0] div_q;
    logic             off_q;
    logic             owner_q;

    logic [1:0]    addr_a [NUM_PORTS];
    logic [DW-1:0] rd_a   [NUM_PORTS];

    assign addr_a[PORT_MAIN] = m_addr;
    assign addr_a[PORT_SEC]  = s_addr;
    assign m_rdata = rd_a[PORT_MAIN];
    assign s_rdata = rd_a[PORT_SEC];

    clkarb_core #(
        .DW(DW), .PLL_W(PLL_W), .DIV_W(DIV_W), .KEY_W(KEY_W),
        .KEY_LSB(KEY_LSB), .KEY(KEY), .PLL_RST(PLL_RST)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .m_we    (m_we),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .s_we    (s_we),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .pll_q   (pll_q),
        .div_q   (div_q),
        .off_q   (off_q),
        .owner_q (owner_q)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        clkarb_rdmux #(.DW(DW), .PLL_W(PLL_W), .DIV_W(DIV_W)) u_rd (
            .addr  (addr_a[p]),
            .pll   (pll_q),
            .div   (div_q),
            .off   (off_q),
            .owner (owner_q),
            .rdata (rd_a[p])
        );
    end

    clkarb_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .off   (off_q),
        .en    (sec_clk_en),
        .gclk  (sec_clk)
    );

endmodule

// File: rtl/clkarb_chk.sv
module clkarb_chk #(
    parameter int DW      = 16,
    parameter int PLL_W   = 7,
    parameter int KEY_W   = 8,
    parameter int KEY_LSB = 8,
    parameter logic [KEY_W-1:0] KEY     = 8'hA5,
    parameter logic [PLL_W-1:0] PLL_RST = 7'd1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             m_we,
    input logic [1:0]       m_addr,
    input logic             s_we,
    input logic [1:0]       s_addr,
    input logic [DW-1:0]    s_wdata,
    input logic [PLL_W-1:0] pll_q,
    input logic             off_q,
    input logic             owner_q,
    input logic             sec_clk_en
);

    assert_rst_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!owner_q && !off_q && pll_q == PLL_RST));

    assert_sec_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_q && s_we && s_addr == 2'd0 && !(m_we && m_addr == 2'd0)) |=> $stable(pll_q));

    assert_key_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && s_addr == 2'd3 && s_wdata[KEY_LSB +: KEY_W] == KEY) |=> (owner_q == $past(s_wdata[0])));

    assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && s_addr == 2'd3 && s_wdata[KEY_LSB +: KEY_W] != KEY) |=> $stable(owner_q));

    assert_main_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q && m_we && m_addr == 2'd0 && !(s_we && s_addr == 2'd0)) |=> $stable(pll_q));

    assert_gate_main_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && s_addr == 2'd2 && !(m_we && m_addr == 2'd2)) |=> $stable(off_q));

    assert_en_tracks_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_clk_en == !off_q);

    always @(sec_clk_en) begin
        if (rst_n === 1'b1) begin
            assert_en_low_R10: assert (clk == 1'b0);
        end
    end

endmodule

bind clkarb_top clkarb_chk #(
    .DW(DW), .PLL_W(PLL_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB),
    .KEY(KEY), .PLL_RST(PLL_RST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .s_we       (s_we),
    .s_addr     (s_addr),
    .s_wdata    (s_wdata),
    .pll_q      (pll_q),
    .off_q      (off_q),
    .owner_q    (owner_q),
    .sec_clk_en (sec_clk_en)
);

// File: tb/sim_clkarb_top.sv
module sim_clkarb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_we = 1'b0, s_we = 1'b0;
    logic [1:0]  m_addr = '0, s_addr = '0;
    logic [15:0] m_wdata = '0, s_wdata = '0;
    logic [15:0] m_rdata, s_rdata;
    logic        sec_clk_en, sec_clk;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        int          kind;   // 0: m_rdata, 1: s_rdata, 2: sec_clk_en
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    clkarb_top u0 (
        .clk(clk), .rst_n(rst_n),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .sec_clk_en(sec_clk_en), .sec_clk(sec_clk)
    );

    // Monitor: results are compared in the low phase, 2 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = m_rdata;
                    1:       act = s_rdata;
                    default: act = {15'd0, sec_clk_en};
                endcase
                n_vec++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        m_we = 1'b0;
        s_we = 1'b0;
    endtask

    task automatic wr_m(input logic [1:0] a, input logic [15:0] d);
        cyc();
        m_we = 1'b1; m_addr = a; m_wdata = d;
    endtask

    task automatic wr_s(input logic [1:0] a, input logic [15:0] d);
        cyc();
        s_we = 1'b1; s_addr = a; s_wdata = d;
    endtask

    task automatic wr_both(input logic [1:0] a, input logic [15:0] dm, input logic [15:0] ds);
        cyc();
        m_we = 1'b1; m_addr = a; m_wdata = dm;
        s_we = 1'b1; s_addr = a; s_wdata = ds;
    endtask

    // Driver: sets read addresses on both ports and queues the expected data.
    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t im, is;
        cyc();
        m_addr = a; s_addr = a;
        im.kind = 0; im.exp = e; im.tag = {tag, " main port"};
        is.kind = 1; is.exp = e; is.tag = {tag, " secondary port"};
        sb_q.push_back(im);
        sb_q.push_back(is);
    endtask

    task automatic exp_en(input logic e, input string tag);
        item_t it;
        cyc();
        it.kind = 2; it.exp = {15'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // High-phase check, 1 ns after the rising edge.
    task automatic chk_high(input logic e, input string tag);
        cyc();
        n_vec++;
        if (sec_clk_en !== e || sec_clk !== e) begin
            n_err++;
            $display("FAIL %s: actual en=%b gclk=%b expected %b", tag, sec_clk_en, sec_clk, e);
        end
    endtask

    task automatic check_defaults(input string tag);
        rd(2'd0, 16'h0001, {tag, " R1 pll"});
        rd(2'd1, 16'h0000, {tag, " R1 div"});
        rd(2'd2, 16'h0000, {tag, " R1 off"});
        rd(2'd3, 16'h0000, {tag, " R1 R7 sem"});
        exp_en(1'b1, {tag, " R1 enable"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_defaults("reset");

        // R2, R11: main writes while it owns; upper bits dropped
        wr_m(2'd0, 16'h1234);
        rd(2'd0, 16'h0034, "R2 R11 pll write");
        wr_m(2'd1, 16'h00FF);
        rd(2'd1, 16'h0007, "R2 R11 div write");

        // R3: secondary writes ignored without ownership
        wr_s(2'd0, 16'h0005);
        rd(2'd0, 16'h0034, "R3 pll unchanged");
        wr_s(2'd1, 16'h0000);
        rd(2'd1, 16'h0007, "R3 div unchanged");

        // R4: bad key and main-port semaphore writes ignored
        wr_s(2'd3, 16'h5A01);
        rd(2'd3, 16'h0000, "R4 wrong key");
        wr_m(2'd3, 16'hA501);
        rd(2'd3, 16'h0000, "R4 main sem write");

        // R4, R7: claim with key
        wr_s(2'd3, 16'hA5FF);
        rd(2'd3, 16'h0001, "R4 R7 claimed");

        // R5: owner switched
        wr_s(2'd0, 16'h0022);
        rd(2'd0, 16'h0022, "R5 secondary write");
        wr_m(2'd0, 16'h0011);
        rd(2'd0, 16'h0022, "R5 main ignored");
        wr_m(2'd1, 16'h0002);
        rd(2'd1, 16'h0007, "R5 main div ignored");

        // R6: collision under secondary ownership
        wr_both(2'd1, 16'h0001, 16'h0005);
        rd(2'd1, 16'h0005, "R6 secondary wins");

        // R4: release, then R6 collision under main ownership
        wr_s(2'd3, 16'hA500);
        rd(2'd3, 16'h0000, "R4 released");
        wr_both(2'd0, 16'h000A, 16'h000B);
        rd(2'd0, 16'h000A, "R6 main wins");

        // R8: secondary cannot gate
        wr_s(2'd2, 16'h0001);
        rd(2'd2, 16'h0000, "R8 secondary gate ignored");
        exp_en(1'b1, "R8 enable kept");

        // R9, R10: main gates off; enable waits for falling edge
        wr_m(2'd2, 16'h0001);
        chk_high(1'b1, "R9 R10 enable held in high phase");
        exp_en(1'b0, "R9 enable off");
        chk_high(1'b0, "R10 gated clock low");
        rd(2'd2, 16'h0001, "R8 off readback");

        wr_m(2'd2, 16'h0000);
        chk_high(1'b0, "R9 R10 off held in high phase");
        exp_en(1'b1, "R9 enable on");
        chk_high(1'b1, "R10 gated clock high");

        // R1: reset in mid-run after changing state
        wr_s(2'd3, 16'hA501);
        wr_m(2'd2, 16'h0001);
        cyc();
        cyc();
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        check_defaults("mid reset");

        cyc();
        cyc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule